// File: doc/BRIEF.md
# Interruption Entry State Sequencer

This block performs the architectural register update that happens when a processor core accepts an interruption. It takes a one-cycle accept strobe with a vector number, or a non-maskable transfer-of-control request, and updates the state in a single clock edge. The old status word is saved. A new, mostly cleared status word is produced. The space and offset parts of the instruction address queues are captured into save registers, with each capture conditioned on the old status bits. A bank of shadow registers may take copies of seven general register values. The front and back instruction offsets of the handler are computed from the vector base or from the firmware entry address.

The core pipeline drives the present state on the inputs and pulses `accept`. One edge later every output register holds its new value, and `done` is high for that one cycle. When no accept strobe arrives, every output register keeps its value. Address translation and fetching of the faulting instruction are outside the block. The fetched word and a flag saying whether it could be read arrive as inputs.

Top module: `intr_entry_seq`

## Requirements
- R1: One edge after `accept` is sampled high, all output registers carry the new state and `done` is high for exactly one cycle. Without `accept`, no output register changes, whatever the other inputs do.
- R2: `saved_psw` receives the status word as it was at the accept edge.
- R3: `psw_new` has every bit clear except two. Bit 12 (wide) is set when `dflt_wide` is 1. Bit 4 (machine-check) is set when `vec` equals 1 and `toc` is 0.
- R4: When bit 5 (translation) of the old status word is set, `sv_space_f` and `sv_space_b` receive `space_f` and `space_b`. When it is clear, both become zero.
- R5: When bit 12 (wide) of the old status word is set, `sv_off_f` and `sv_off_b` receive the full `off_f` and `off_b`. When it is clear, they receive only the low 32 bits, and the upper bits are zero.
- R6: When bit 3 (queue-save) of the old status word is set, `shadow[k]` takes `gr_pick[k]` for k = 0..6. The seven `gr_pick` entries are general registers 1, 8, 9, 16, 17, 24 and 25, in that order. When the bit is clear, the shadow bank keeps its contents.
- R7: For an ordinary vector (`toc` = 0), `new_off_f` = `vec_base` + 32 x `vec` and `new_off_b` = `new_off_f` + 4. `new_space` is zero after every accept.
- R8: For a transfer of control (`toc` = 1), `new_off_f` = `fw_start` and `new_off_b` = `fw_start` + 4, and `gr_load` pulses with `gr24_val` equal to the new `sv_space_b` (zero-extended) and `gr25_val` equal to the new `sv_off_b`. For ordinary vectors `gr_load` stays low.
- R9: When bit 3 of the old status word is set, `toc` is 0 and `vec` lies in 14..27, `iir` receives `insn_word` if `insn_ok` is 1, or zero if it is 0. In every other case `iir` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| accept | input | 1 | One-cycle strobe: interruption accepted |
| toc | input | 1 | Non-maskable transfer-of-control request, qualifies `accept` |
| vec | input | 5 | Vector number |
| psw_in | input | 64 | Current status word |
| dflt_wide | input | 1 | Default wide flag for the new status word |
| space_f | input | 32 | Front space (upper half of the front global address) |
| space_b | input | 32 | Back space (upper half of the back global address) |
| off_f | input | 64 | Front instruction offset |
| off_b | input | 64 | Back instruction offset |
| gr_pick | input | 7x64 | General registers 1, 8, 9, 16, 17, 24, 25 |
| vec_base | input | 64 | Interruption vector base |
| fw_start | input | 64 | Firmware entry offset |
| insn_word | input | 32 | Faulting instruction word |
| insn_ok | input | 1 | The instruction word could be fetched |
| done | output | 1 | Update completed (one cycle) |
| saved_psw | output | 64 | Saved status word |
| psw_new | output | 64 | New status word |
| sv_space_f | output | 32 | Saved front space |
| sv_space_b | output | 32 | Saved back space |
| sv_off_f | output | 64 | Saved front offset |
| sv_off_b | output | 64 | Saved back offset |
| shadow | output | 7x64 | Shadow register bank |
| iir | output | 32 | Interruption instruction register |
| new_off_f | output | 64 | New front offset |
| new_off_b | output | 64 | New back offset |
| new_space | output | 32 | New space for both queue entries |
| gr_load | output | 1 | Write strobe for general registers 24 and 25 |
| gr24_val | output | 64 | Value for general register 24 |
| gr25_val | output | 64 | Value for general register 25 |

## Verification
The assertions take `accept` to be a pulse that the pipeline never holds high on two edges in a row. They also take the inputs to be stable around the edge where it is sampled, and they compare each update with the inputs of the previous cycle through `$past`. The stimulus therefore lowers `accept` on the falling edge after each accepted update. It changes inputs only on falling edges. During its idle checks it alters every data input while the strobe stays low, so that the hold property is exercised with moving inputs.

// File: rtl/ie_pkg.sv
package ie_pkg;
  // Status word bit positions decoded by the sequencer
  localparam int QSAVE_BIT = 3;
  localparam int MCHK_BIT  = 4;
  localparam int XLATE_BIT = 5;
  localparam int WIDE_BIT  = 12;
  // Vector numbers with special meaning
  localparam int MCHK_VEC  = 1;
  localparam int FETCH_LO  = 14;
  localparam int FETCH_HI  = 27;
  localparam int OFF_STEP  = 4;
endpackage

// File: rtl/ie_status_unit.sv
module ie_status_unit #(
  parameter int XLEN  = 64,
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             toc,
  input  logic [VEC_W-1:0] vec,
  input  logic [XLEN-1:0]  psw_in,
  input  logic             dflt_wide,
  output logic [XLEN-1:0]  saved_psw,
  output logic [XLEN-1:0]  psw_new
);
  import ie_pkg::*;

  function automatic logic [XLEN-1:0] entry_psw(input logic wide, input logic mchk);
    logic [XLEN-1:0] p;
    p = '0;
    p[WIDE_BIT] = wide;
    p[MCHK_BIT] = mchk;
    return p;
  endfunction

  logic is_mchk;
  assign is_mchk = !toc && (int'(vec) == MCHK_VEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_psw <= '0;
      psw_new   <= '0;
    end else if (fire) begin
      saved_psw <= psw_in;
      psw_new   <= entry_psw(dflt_wide, is_mchk);
    end
  end

  AST_PSW_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> saved_psw == $past(psw_in)); // R2
  AST_PSW_FEW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> $countones(psw_new) <= 2); // R3
endmodule

// File: rtl/ie_queue_save.sv
module ie_queue_save #(
  parameter int XLEN  = 64,
  parameter int SPC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             xlate,
  input  logic             wide,
  input  logic [SPC_W-1:0] space_f,
  input  logic [SPC_W-1:0] space_b,
  input  logic [XLEN-1:0]  off_f,
  input  logic [XLEN-1:0]  off_b,
  output logic [SPC_W-1:0] sv_space_f,
  output logic [SPC_W-1:0] sv_space_b,
  output logic [XLEN-1:0]  sv_off_f,
  output logic [XLEN-1:0]  sv_off_b
);
  localparam int NARROW = 32;

  function automatic logic [XLEN-1:0] fit_offset(input logic [XLEN-1:0] o, input logic w);
    return w ? o : {{(XLEN-NARROW){1'b0}}, o[NARROW-1:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_space_f <= '0;
      sv_space_b <= '0;
      sv_off_f   <= '0;
      sv_off_b   <= '0;
    end else if (fire) begin
      sv_space_f <= xlate ? space_f : '0;
      sv_space_b <= xlate ? space_b : '0;
      sv_off_f   <= fit_offset(off_f, wide);
      sv_off_b   <= fit_offset(off_b, wide);
    end
  end

  AST_SPACE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !xlate |=> sv_space_f == '0 && sv_space_b == '0); // R4
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !wide |=> sv_off_f[XLEN-1:NARROW] == '0 && sv_off_b[XLEN-1:NARROW] == '0); // R5
endmodule

// File: rtl/ie_shadow_bank.sv
module ie_shadow_bank #(
  parameter int XLEN = 64,
  parameter int NSH  = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fire,
  input  logic                     qsave,
  input  logic [NSH-1:0][XLEN-1:0] gr_pick,
  output logic [NSH-1:0][XLEN-1:0] shadow
);
  logic take;
  assign take = fire && qsave;

  for (genvar k = 0; k < NSH; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     shadow[k] <= '0;
      else if (take)  shadow[k] <= gr_pick[k];
    end
  end

  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(shadow)); // R6
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq #(
  parameter int XLEN  = 64,
  parameter int VEC_W = 5,
  parameter int SPC_W = 32,
  parameter int NSH   = 7,
  parameter int IW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     toc,
  input  logic [VEC_W-1:0]         vec,
  input  logic [XLEN-1:0]          psw_in,
  input  logic                     dflt_wide,
  input  logic [SPC_W-1:0]         space_f,
  input  logic [SPC_W-1:0]         space_b,
  input  logic [XLEN-1:0]          off_f,
  input  logic [XLEN-1:0]          off_b,
  input  logic [NSH-1:0][XLEN-1:0] gr_pick,
  input  logic [XLEN-1:0]          vec_base,
  input  logic [XLEN-1:0]          fw_start,
  input  logic [IW-1:0]            insn_word,
  input  logic                     insn_ok,
  output logic                     done,
  output logic [XLEN-1:0]          saved_psw,
  output logic [XLEN-1:0]          psw_new,
  output logic [SPC_W-1:0]         sv_space_f,
  output logic [SPC_W-1:0]         sv_space_b,
  output logic [XLEN-1:0]          sv_off_f,
  output logic [XLEN-1:0]          sv_off_b,
  output logic [NSH-1:0][XLEN-1:0] shadow,
  output logic [IW-1:0]            iir,
  output logic [XLEN-1:0]          new_off_f,
  output logic [XLEN-1:0]          new_off_b,
  output logic [SPC_W-1:0]         new_space,
  output logic                     gr_load,
  output logic [XLEN-1:0]          gr24_val,
  output logic [XLEN-1:0]          gr25_val
);
  import ie_pkg::*;
  localparam int SLOT_SH = 5; // 32-byte handler slots

  function automatic logic [XLEN-1:0] slot_addr(input logic [XLEN-1:0] base,
                                                input logic [VEC_W-1:0] v);
    return base + (XLEN'(v) << SLOT_SH);
  endfunction

  function automatic logic in_fetch_set(input logic [VEC_W-1:0] v);
    return (int'(v) >= FETCH_LO) && (int'(v) <= FETCH_HI);
  endfunction

  // Named internal events
  logic old_q, old_c, old_w, iir_take;
  logic [XLEN-1:0] front_tgt;
  assign old_q     = psw_in[QSAVE_BIT];
  assign old_c     = psw_in[XLATE_BIT];
  assign old_w     = psw_in[WIDE_BIT];
  assign iir_take  = accept && old_q && !toc && in_fetch_set(vec);
  assign front_tgt = toc ? fw_start : slot_addr(vec_base, vec);

  ie_status_unit #(.XLEN(XLEN), .VEC_W(VEC_W)) u_status (
    .clk(clk), .rst_n(rst_n), .fire(accept), .toc(toc), .vec(vec),
    .psw_in(psw_in), .dflt_wide(dflt_wide),
    .saved_psw(saved_psw), .psw_new(psw_new));

  ie_queue_save #(.XLEN(XLEN), .SPC_W(SPC_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .fire(accept), .xlate(old_c), .wide(old_w),
    .space_f(space_f), .space_b(space_b), .off_f(off_f), .off_b(off_b),
    .sv_space_f(sv_space_f), .sv_space_b(sv_space_b),
    .sv_off_f(sv_off_f), .sv_off_b(sv_off_b));

  ie_shadow_bank #(.XLEN(XLEN), .NSH(NSH)) u_shadow (
    .clk(clk), .rst_n(rst_n), .fire(accept), .qsave(old_q),
    .gr_pick(gr_pick), .shadow(shadow));

  assign new_space = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      iir       <= '0;
      new_off_f <= '0;
      new_off_b <= '0;
      gr_load   <= 1'b0;
      gr24_val  <= '0;
      gr25_val  <= '0;
    end else begin
      done    <= accept;
      gr_load <= accept && toc;
      if (iir_take) iir <= insn_ok ? insn_word : '0;
      if (accept) begin
        new_off_f <= front_tgt;
        new_off_b <= front_tgt + XLEN'(OFF_STEP);
      end
      if (accept && toc) begin
        gr24_val <= XLEN'(old_c ? space_b : '0);
        gr25_val <= old_w ? off_b : {{(XLEN-32){1'b0}}, off_b[31:0]};
      end
    end
  end

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> done); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !done && $stable(saved_psw) && $stable(new_off_f) && $stable(sv_off_b)); // R1
  AST_BACK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> new_off_b == new_off_f + XLEN'(OFF_STEP)); // R7
  AST_GR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    gr_load |-> gr25_val == sv_off_b && gr24_val == XLEN'(sv_space_b)); // R8
  AST_IIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !iir_take |=> $stable(iir)); // R9
endmodule

// File: tb/test_intr_entry_seq.sv
module test_intr_entry_seq;
  localparam int XLEN = 64, NSH = 7, NROW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic accept = 1'b0, toc = 1'b0, dflt_wide = 1'b0, insn_ok = 1'b0;
  logic [4:0] vec = '0;
  logic [63:0] psw_in = '0, off_f = '0, off_b = '0, vec_base = '0, fw_start = '0;
  logic [31:0] space_f = '0, space_b = '0, insn_word = '0;
  logic [NSH-1:0][63:0] gr_pick = '0;
  logic done, gr_load;
  logic [63:0] saved_psw, psw_new, sv_off_f, sv_off_b, new_off_f, new_off_b, gr24_val, gr25_val;
  logic [31:0] sv_space_f, sv_space_b, iir, new_space;
  logic [NSH-1:0][63:0] shadow;

  always #5 clk = ~clk;

  intr_entry_seq i_intr_entry_seq (.*);

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Stimulus table: vec, psw, toc, dflt_wide, insn_ok
  localparam logic [4:0]  T_VEC [NROW] = '{5'd5, 5'd1, 5'd15, 5'd20, 5'd9, 5'd31, 5'd27};
  localparam logic [63:0] T_PSW [NROW] = '{64'h8000_0000_0000_1028, 64'h0000_0000_0000_1000,
    64'h0000_0000_0000_0008, 64'h0000_0000_0000_0028, 64'h0000_0000_0000_1028,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000};
  localparam logic T_TOC [NROW] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic T_WID [NROW] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic T_OK  [NROW] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

  logic [NSH-1:0][63:0] m_shadow = '0;
  logic [31:0] m_iir = '0;

  task automatic load_row(input int r);
    vec = T_VEC[r]; psw_in = T_PSW[r]; toc = T_TOC[r];
    dflt_wide = T_WID[r]; insn_ok = T_OK[r];
    insn_word = 32'hC0DE_0000 + 32'(r);
    space_f = 32'hA5A5_0000 + 32'(r); space_b = 32'h5A5A_0000 + 32'(r);
    off_f = 64'h1234_5678_9ABC_DE00 + 64'(r * 8); off_b = off_f + 64'd4;
    for (int k = 0; k < NSH; k++) gr_pick[k] = 64'hDEAD_0000_0000_0000 | 64'(r * 256 + k);
  endtask

  task automatic run_row(input int r);
    logic q, c, w;
    logic [63:0] ep, ef, eb_sv;
    @(negedge clk);
    load_row(r);
    accept = 1'b1;
    q = psw_in[3]; c = psw_in[5]; w = psw_in[12];
    if (q) m_shadow = gr_pick;
    if (q && !toc && vec >= 5'd14 && vec <= 5'd27) m_iir = insn_ok ? insn_word : 32'h0;
    ep = 64'h0;
    if (dflt_wide) ep = ep + 64'h1000;
    if (!toc && vec == 5'd1) ep = ep + 64'h10;
    ef = toc ? fw_start : vec_base + 64'(vec) * 64'd32;
    eb_sv = w ? off_b : (off_b & 64'h0000_0000_FFFF_FFFF);
    @(negedge clk);
    accept = 1'b0;
    chk("R1", "done", 64'(done), 64'd1);
    chk("R2", "saved_psw", saved_psw, psw_in);
    chk("R3", "psw_new", psw_new, ep);
    chk("R4", "sv_space_f", 64'(sv_space_f), c ? 64'(space_f) : 64'h0);
    chk("R4", "sv_space_b", 64'(sv_space_b), c ? 64'(space_b) : 64'h0);
    chk("R5", "sv_off_f", sv_off_f, w ? off_f : (off_f & 64'h0000_0000_FFFF_FFFF));
    chk("R5", "sv_off_b", sv_off_b, eb_sv);
    for (int k = 0; k < NSH; k++) chk("R6", "shadow", shadow[k], m_shadow[k]);
    chk(toc ? "R8" : "R7", "new_off_f", new_off_f, ef);
    chk(toc ? "R8" : "R7", "new_off_b", new_off_b, ef + 64'd4);
    chk("R7", "new_space", 64'(new_space), 64'h0);
    chk("R8", "gr_load", 64'(gr_load), 64'(toc));
    if (toc) begin
      chk("R8", "gr24_val", gr24_val, c ? 64'(space_b) : 64'h0);
      chk("R8", "gr25_val", gr25_val, eb_sv);
    end
    chk("R9", "iir", 64'(iir), 64'(m_iir));
    @(negedge clk);
    chk("R1", "done drop", 64'(done), 64'd0);
    chk("R8", "gr_load drop", 64'(gr_load), 64'd0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] hold_psw, hold_off, hold_sh0;
    logic [31:0] hold_iir;
    vec_base = 64'h0000_0000_8000_0000;
    fw_start = 64'h0000_0000_F000_0000;
    repeat (3) @(negedge clk);
    // Reset state
    chk("R1", "reset done", 64'(done), 64'd0);
    chk("R2", "reset saved_psw", saved_psw, 64'h0);
    chk("R9", "reset iir", 64'(iir), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int r = 0; r < NROW; r++) run_row(r);
    // Idle: inputs move, no strobe, nothing changes (R1, R6, R9)
    hold_psw = saved_psw; hold_off = new_off_f; hold_sh0 = shadow[0]; hold_iir = iir;
    load_row(3);
    psw_in = 64'hFFFF_FFFF_FFFF_FFFF; vec = 5'd16; toc = 1'b1;
    vec_base = 64'h1111_0000; fw_start = 64'h2222_0000;
    repeat (4) @(negedge clk);
    chk("R1", "idle done", 64'(done), 64'd0);
    chk("R1", "idle saved_psw", saved_psw, hold_psw);
    chk("R1", "idle new_off_f", new_off_f, hold_off);
    chk("R6", "idle shadow", shadow[0], hold_sh0);
    chk("R9", "idle iir", 64'(iir), 64'(hold_iir));
    chk("R8", "idle gr_load", 64'(gr_load), 64'd0);
    // Vector base change applies on next accept
    vec_base = 64'h0000_0000_8000_0000; fw_start = 64'h0000_0000_F000_0000;
    run_row(0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule